// File: doc/BRIEF.md
# Dual-Half Configurable Timer

The block is a bus-mapped timer with two 32-bit counters, a low half and a high half. Each half has its own period register and its own two-bit enable field, so one half can count while the other is off. Software reaches every register through a single-cycle write strobe with a word address and reads through a combinational read port. A global control register picks how the halves cooperate and can hold either half frozen, whatever its enable field says.

Only the dual unchained 32-bit timer mode makes the halves count. The other three timer-mode codes are stored and read back but freeze both counters. In periodic mode a half counts up to its period, emits a one-cycle terminal pulse and restarts from zero. In one-shot mode it stops on its period, pulses once and clears its own enable field, so software sees the field return to the off code.

Top module: `twin_half_timer`

## Requirements
- R1: After a synchronous active-low reset, every counter, period, enable field and global bit is zero, both terminal pulses are low, and word address 0 reads the ID_VALUE parameter.
- R2: Word addresses: 0 ID, 4 low counter, 5 high counter, 6 low period, 7 high period, 8 enable control, 9 global control, 10 watchdog control; a written counter or period reads back the written value.
- R3: The enable control word holds the low half's field at bits 7:6 and the high half's at bits 23:22, with codes 0 off, 1 one-shot, 2 periodic; code 3 is stored and reads back but does not count.
- R4: In periodic mode a running half adds one per clock; on the clock edge where its count equals its period it returns to zero and its terminal pulse is high for the following cycle.
- R5: In one-shot mode a running half stops on the edge where its count equals its period, keeps that count, pulses its terminal output for one cycle and its enable field reads 0 afterwards.
- R6: Writing the off code stops a half and keeps its current count.
- R7: Global control bit 0 (low half) and bit 1 (high half) release a half; while its bit is 0 that half's count holds and its pulse stays low, and the other half is unaffected.
- R8: Global control bits 3:2 select the timer mode (0 64-bit general, 1 dual unchained 32-bit, 2 64-bit watchdog, 3 chained 32-bit); only code 1 lets the halves count.
- R9: A software write to a counter in the same cycle as a counting step wins: the counter takes the written value and no terminal pulse results from that cycle.
- R10: A software write to the enable control word in the same cycle as a one-shot end leaves the written fields in place, while the terminal pulse still occurs.
- R11: Unused register bits, unused addresses and the watchdog control word read zero; writes to the ID and watchdog control words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tc_pulse | output | 2 | Terminal pulse, bit 0 low half, bit 1 high half |

## Verification
The functions that can meet in one cycle are the hardware clearing of a one-shot enable field and a software write to the same control word, and likewise a counting step and a software counter write. The bench arranges a one-shot half with period 2 and writes the periodic code exactly on the third edge after enabling it, then expects the periodic code to read back while the terminal pulse still fires; it also writes a counter equal to its period and expects no pulse that cycle. The random phase mixes counter, period, control and global writes with small values so both collisions recur, and a cycle-level model in the bench judges every pulse and readback.

// File: rtl/twin_timer_pkg.sv
// Shared constants and types for the dual-half timer.
// Assumes a 32-bit data bus and word addressing.
package twin_timer_pkg;

    localparam int DATA_W    = 32;
    localparam int EN_W      = 2;
    localparam int GLB_W     = 4;
    localparam int EN_LSB_LO = 6;
    localparam int EN_LSB_HI = 22;

    typedef enum logic [1:0] {
        EN_OFF      = 2'd0,
        EN_ONESHOT  = 2'd1,
        EN_PERIODIC = 2'd2,
        EN_RSVD     = 2'd3
    } en_mode_e;

    typedef enum logic [1:0] {
        TM_GP64    = 2'd0,
        TM_DUAL32  = 2'd1,
        TM_WD64    = 2'd2,
        TM_CHAIN32 = 2'd3
    } tmr_mode_e;

    localparam logic [3:0] WA_ID     = 4'd0;
    localparam logic [3:0] WA_CNT_LO = 4'd4;
    localparam logic [3:0] WA_CNT_HI = 4'd5;
    localparam logic [3:0] WA_PRD_LO = 4'd6;
    localparam logic [3:0] WA_PRD_HI = 4'd7;
    localparam logic [3:0] WA_CTRL   = 4'd8;
    localparam logic [3:0] WA_GLOBAL = 4'd9;
    localparam logic [3:0] WA_WDOG   = 4'd10;

endpackage

// File: rtl/twin_timer_half.sv
// One counter half: count register, period register and terminal pulse.
// Assumes run already combines the release bit and the timer mode, and
// that mode is the live enable field held by the register block.
module twin_timer_half
    import twin_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EN_W-1:0]  mode,
    input  logic             cnt_we,
    input  logic             prd_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] prd,
    output logic             tc,
    output logic             oneshot_done
);

    logic stepping;
    logic at_end;

    // A step happens only for a counting code and no software counter write.
    assign stepping     = run && (mode == EN_ONESHOT || mode == EN_PERIODIC) && !cnt_we;
    assign at_end       = stepping && (cnt == prd);
    assign oneshot_done = at_end && (mode == EN_ONESHOT);

    // Counter: software write first, then terminal handling, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_we) begin
            cnt <= wdata;
        end else if (at_end) begin
            if (mode == EN_PERIODIC) begin
                cnt <= '0;
            end
        end else if (stepping) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Period register, software written only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd <= '0;
        end else if (prd_we) begin
            prd <= wdata;
        end
    end

    // Terminal pulse, high for the cycle after the terminal edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= 1'b0;
        end else begin
            tc <= at_end;
        end
    end

    a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !at_end) |=> (cnt == $past(cnt) + 1'b1) && !tc);

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && mode == EN_PERIODIC) |=> (cnt == '0) && tc);

    a_r5_hold_end: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && mode == EN_ONESHOT) |=> $stable(cnt) && tc);

    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(cnt) && !tc);

    a_r9_sw_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt == $past(wdata)) && !tc);

endmodule

// File: rtl/twin_timer_regs.sv
// Register block: address decode, enable fields, global control and
// read multiplexer. Assumes a one-cycle write strobe and that the halves
// report a one-shot end in the same cycle as their terminal edge.
module twin_timer_regs
    import twin_timer_pkg::*;
#(
    parameter int          CNT_W    = 32,
    parameter int          ADDR_W   = 4,
    parameter logic [31:0] ID_VALUE = 32'h5417_0203
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [2*EN_W-1:0]          en_wdata,
    input  logic [GLB_W-1:0]           glb_wdata,
    input  logic [1:0]                 oneshot_done,
    input  logic [1:0][CNT_W-1:0]      cnt_i,
    input  logic [1:0][CNT_W-1:0]      prd_i,
    output logic [1:0][EN_W-1:0]       mode_o,
    output logic [1:0]                 run_o,
    output logic [1:0]                 cnt_we_o,
    output logic [1:0]                 prd_we_o,
    output logic [DATA_W-1:0]          bus_rdata
);

    logic             ctrl_we;
    logic             glb_we;
    logic [GLB_W-1:0] glb_q;
    logic             dual_mode;

    // Write strobes decoded from the word address.
    assign ctrl_we     = bus_wr && (bus_addr == ADDR_W'(WA_CTRL));
    assign glb_we      = bus_wr && (bus_addr == ADDR_W'(WA_GLOBAL));
    assign cnt_we_o[0] = bus_wr && (bus_addr == ADDR_W'(WA_CNT_LO));
    assign cnt_we_o[1] = bus_wr && (bus_addr == ADDR_W'(WA_CNT_HI));
    assign prd_we_o[0] = bus_wr && (bus_addr == ADDR_W'(WA_PRD_LO));
    assign prd_we_o[1] = bus_wr && (bus_addr == ADDR_W'(WA_PRD_HI));

    // Global control: release bits and timer mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q <= '0;
        end else if (glb_we) begin
            glb_q <= glb_wdata;
        end
    end

    assign dual_mode = (glb_q[3:2] == TM_DUAL32);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [EN_W-1:0] field_q;

        // Enable field: software write wins over the one-shot clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                field_q <= EN_OFF;
            end else if (ctrl_we) begin
                field_q <= en_wdata[h*EN_W +: EN_W];
            end else if (oneshot_done[h]) begin
                field_q <= EN_OFF;
            end
        end

        assign mode_o[h] = field_q;
        assign run_o[h]  = glb_q[h] && dual_mode;

        a_r5_field_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (oneshot_done[h] && !ctrl_we) |=> (field_q == EN_OFF));

        a_r10_ctrl_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_we |=> (field_q == $past(en_wdata[h*EN_W +: EN_W])));
    end

    // Read multiplexer; unused bits and addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(WA_ID):     bus_rdata = ID_VALUE;
            ADDR_W'(WA_CNT_LO): bus_rdata = DATA_W'(cnt_i[0]);
            ADDR_W'(WA_CNT_HI): bus_rdata = DATA_W'(cnt_i[1]);
            ADDR_W'(WA_PRD_LO): bus_rdata = DATA_W'(prd_i[0]);
            ADDR_W'(WA_PRD_HI): bus_rdata = DATA_W'(prd_i[1]);
            ADDR_W'(WA_CTRL): begin
                bus_rdata[EN_LSB_LO +: EN_W] = mode_o[0];
                bus_rdata[EN_LSB_HI +: EN_W] = mode_o[1];
            end
            ADDR_W'(WA_GLOBAL): bus_rdata[GLB_W-1:0] = glb_q;
            default:            bus_rdata = '0;
        endcase
    end

    a_r7_release_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_we && glb_wdata[1:0] == 2'b00) |=> (run_o == 2'b00));

endmodule

// File: rtl/twin_half_timer.sv
// Top of the dual-half timer: one register block and two counter halves.
// Assumes CNT_W does not exceed the 32-bit data bus.
module twin_half_timer
    import twin_timer_pkg::*;
#(
    parameter int          CNT_W    = 32,
    parameter int          ADDR_W   = 4,
    parameter logic [31:0] ID_VALUE = 32'h5417_0203
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        tc_pulse
);

    logic [1:0][EN_W-1:0]  mode;
    logic [1:0]            run;
    logic [1:0]            cnt_we;
    logic [1:0]            prd_we;
    logic [1:0]            oneshot_done;
    logic [1:0][CNT_W-1:0] cnt;
    logic [1:0][CNT_W-1:0] prd;

    twin_timer_regs #(
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .ID_VALUE (ID_VALUE)
    ) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .en_wdata     ({bus_wdata[EN_LSB_HI +: EN_W], bus_wdata[EN_LSB_LO +: EN_W]}),
        .glb_wdata    (bus_wdata[GLB_W-1:0]),
        .oneshot_done (oneshot_done),
        .cnt_i        (cnt),
        .prd_i        (prd),
        .mode_o       (mode),
        .run_o        (run),
        .cnt_we_o     (cnt_we),
        .prd_we_o     (prd_we),
        .bus_rdata    (bus_rdata)
    );

    for (genvar h = 0; h < 2; h++) begin : g_ctr
        twin_timer_half #(
            .CNT_W (CNT_W)
        ) half_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .run          (run[h]),
            .mode         (mode[h]),
            .cnt_we       (cnt_we[h]),
            .prd_we       (prd_we[h]),
            .wdata        (bus_wdata[CNT_W-1:0]),
            .cnt          (cnt[h]),
            .prd          (prd[h]),
            .tc           (tc_pulse[h]),
            .oneshot_done (oneshot_done[h])
        );
    end

endmodule

// File: tb/twin_half_timer_tb_top.sv
// Bench: directed corner cases then seeded random traffic, judged by a
// cycle-level model written from the requirements.
module twin_half_timer_tb_top;

    localparam int          CLK_P = 10;
    localparam logic [31:0] IDV   = 32'h5417_0203;
    localparam logic [3:0] A_ID = 4'd0, A_CNT_LO = 4'd4, A_CNT_HI = 4'd5,
                           A_PRD_LO = 4'd6, A_PRD_HI = 4'd7, A_CTRL = 4'd8,
                           A_GLB = 4'd9, A_WDOG = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  tc_pulse;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_cnt [2];
    logic [31:0] m_prd [2];
    logic [1:0]  m_mode [2];
    logic        m_tc [2];
    logic [3:0]  m_glb;

    always #(CLK_P/2) clk = ~clk;

    twin_half_timer #(.ID_VALUE(IDV)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tc_pulse  (tc_pulse)
    );

    function automatic logic [31:0] m_read(logic [3:0] a);
        logic [31:0] v = '0;
        case (a)
            A_ID:     v = IDV;
            A_CNT_LO: v = m_cnt[0];
            A_CNT_HI: v = m_cnt[1];
            A_PRD_LO: v = m_prd[0];
            A_PRD_HI: v = m_prd[1];
            A_CTRL:   begin v[7:6] = m_mode[0]; v[23:22] = m_mode[1]; end
            A_GLB:    v[3:0] = m_glb;
            default:  v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int h = 0; h < 2; h++) begin
            m_cnt[h] = '0; m_prd[h] = '0; m_mode[h] = '0; m_tc[h] = 1'b0;
        end
        m_glb = '0;
    endtask

    // One clock edge of the expected behaviour (R4 to R10).
    task automatic model_step(input logic w, input logic [3:0] a, input logic [31:0] d);
        for (int h = 0; h < 2; h++) begin
            logic run, sw, step, term;
            run  = m_glb[h] && (m_glb[3:2] == 2'd1);
            sw   = w && (a == (h == 0 ? A_CNT_LO : A_CNT_HI));
            step = run && (m_mode[h] == 2'd1 || m_mode[h] == 2'd2) && !sw;
            term = step && (m_cnt[h] == m_prd[h]);
            m_tc[h] = term;
            if (sw)                     m_cnt[h] = d;
            else if (term)              m_cnt[h] = (m_mode[h] == 2'd2) ? 32'd0 : m_cnt[h];
            else if (step)              m_cnt[h] = m_cnt[h] + 1;
            if (w && a == A_CTRL)       m_mode[h] = (h == 0) ? d[7:6] : d[23:22];
            else if (term && m_mode[h] == 2'd1) m_mode[h] = 2'd0;
            if (w && a == (h == 0 ? A_PRD_LO : A_PRD_HI)) m_prd[h] = d;
        end
        if (w && a == A_GLB) m_glb = d[3:0];
    endtask

    // Called just after a falling edge: drive, optionally check a read,
    // take one edge, then check both pulses against the model.
    task automatic do_cycle(input logic w, input logic [3:0] a, input logic [31:0] d,
                            input logic rd_chk, input string tag);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        if (rd_chk && !w) chk(bus_rdata, m_read(a), tag);
        @(posedge clk);
        model_step(w, a, d);
        @(negedge clk);
        chk({30'h0, tc_pulse}, {30'h0, m_tc[1], m_tc[0]}, {tag, " pulse"});
        bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        do_cycle(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        do_cycle(1'b0, a, 32'h0, 1'b1, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        chk({30'h0, tc_pulse}, 32'h0, "R1 pulses in reset");
        rst_n = 1'b1;

        // R1, R11: reset values on every address, watchdog and gaps read zero.
        for (int a = 0; a < 12; a++) rd(4'(a), "R1 reset readback");
        bus_addr = A_ID; #1;
        chk(bus_rdata, IDV, "R1 ID value");

        // R2, R4: periodic low half, period 3.
        wr(A_GLB, 32'h7, "R2");
        wr(A_PRD_LO, 32'd3, "R2");
        rd(A_PRD_LO, "R2 period readback");
        wr(A_CTRL, 32'h0000_0080, "R4");
        repeat (10) rd(A_CNT_LO, "R4 periodic count");

        // R6: off code keeps the count.
        wr(A_CTRL, 32'h0, "R6");
        repeat (3) rd(A_CNT_LO, "R6 count kept");

        // R5: one-shot on the high half, period 4.
        wr(A_PRD_HI, 32'd4, "R5");
        wr(A_CNT_HI, 32'd0, "R5");
        wr(A_CTRL, 32'h0040_0000, "R5");
        repeat (8) rd(A_CNT_HI, "R5 one-shot count");
        bus_addr = A_CTRL; #1;
        chk(bus_rdata, 32'h0, "R5 field cleared");
        bus_addr = A_CNT_HI; #1;
        chk(bus_rdata, 32'd4, "R5 count held at period");

        // R7: high half held by its release bit.
        wr(A_PRD_HI, 32'd100, "R7");
        wr(A_CTRL, 32'h0080_0080, "R7");
        wr(A_GLB, 32'h5, "R7");
        repeat (4) begin rd(A_CNT_HI, "R7 held half"); rd(A_CNT_LO, "R7 free half"); end

        // R8: the three non-counting timer modes.
        wr(A_GLB, 32'h3, "R8");
        repeat (3) begin rd(A_CNT_LO, "R8 mode 0"); rd(A_CNT_HI, "R8 mode 0"); end
        wr(A_GLB, 32'hB, "R8");
        repeat (3) rd(A_CNT_LO, "R8 mode 2");
        wr(A_GLB, 32'hF, "R8");
        repeat (3) rd(A_CNT_HI, "R8 mode 3");

        // R9: counter write equal to period gives no pulse that cycle.
        wr(A_GLB, 32'h7, "R9");
        wr(A_CTRL, 32'h0000_0080, "R9");
        wr(A_PRD_LO, 32'd5, "R9");
        wr(A_CNT_LO, 32'd5, "R9");
        chk({31'h0, tc_pulse[0]}, 32'h0, "R9 no pulse on write");
        repeat (4) rd(A_CNT_LO, "R9 after write");

        // R10: control write on the one-shot end edge.
        wr(A_CTRL, 32'h0, "R10");
        wr(A_CNT_LO, 32'd0, "R10");
        wr(A_PRD_LO, 32'd2, "R10");
        wr(A_CTRL, 32'h0000_0040, "R10");
        rd(A_CNT_LO, "R10");
        rd(A_CNT_LO, "R10");
        wr(A_CTRL, 32'h0000_0080, "R10");
        chk({31'h0, tc_pulse[0]}, 32'h1, "R10 pulse still fires");
        bus_addr = A_CTRL; #1;
        chk(bus_rdata, 32'h0000_0080, "R10 written field kept");
        repeat (3) rd(A_CNT_LO, "R10 periodic after");

        // R11 and R3: ignored writes, unused bits, reserved code.
        wr(A_ID, 32'hFFFF_FFFF, "R11");
        rd(A_ID, "R11 ID unchanged");
        wr(A_WDOG, 32'hFFFF_FFFF, "R11");
        rd(A_WDOG, "R11 watchdog reads zero");
        wr(A_CTRL, 32'hFFFF_FFFF, "R3");
        bus_addr = A_CTRL; #1;
        chk(bus_rdata, 32'h00C0_00C0, "R3 field positions");
        repeat (3) rd(A_CNT_LO, "R3 reserved code frozen");
        wr(A_GLB, 32'hFFFF_FFF7, "R11");
        bus_addr = A_GLB; #1;
        chk(bus_rdata, 32'h0000_0007, "R11 global unused bits");

        // Random phase: all registers, small values so collisions recur.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 5 == 0) begin
                logic [3:0]  a;
                logic [31:0] d;
                case ($urandom % 6)
                    0: begin a = A_CNT_LO; d = $urandom % 12; end
                    1: begin a = A_CNT_HI; d = $urandom % 12; end
                    2: begin a = A_PRD_LO; d = $urandom % 12; end
                    3: begin a = A_PRD_HI; d = $urandom % 12; end
                    4: begin a = A_CTRL;   d = $urandom; end
                    default: begin a = A_GLB; d = ($urandom % 5 == 0) ? $urandom : 32'h7; end
                endcase
                wr(a, d, "R4 R5 R9 R10 random");
            end else begin
                rd(4'($urandom % 11), "R4 R5 R9 R10 random");
            end
        end

        finish_run();
    end

endmodule